// File: doc/BRIEF.md
# Long-Press Power Key Controller

This block sits behind an active-low master power switch. The switch pulls the pin to ground, and a pull-up holds the pin high when the switch is open. The block synchronises the pin and debounces it against a millisecond tick. The debounced level is visible at all times. Each change of the debounced level raises an interrupt event.

When a press is accepted, the block runs a programmable first action. If the key is still held after one timeout, it runs a programmable second action. If the key is held for one more timeout, it always issues a power-off request. The timeout counts a one-second tick. A release at any point cancels the stages that have not yet run. Requests leave the block as one-clock pulses, and a power sequencer outside this block acts on them.

The three action and timing fields accept writes only while an external unlock input is high. The interrupt mask and the sticky interrupt flag accept writes at any time.

Top module: `pwr_key_ctrl`

## Requirements
- R1: The pin passes through a two-flop synchroniser. The debounced level follows the synchronised pin only after 4 consecutive millisecond-tick samples that differ from the current level. A differing run shorter than 4 is discarded. `key_sts_o` shows the debounced level: 1 means released and 0 means pressed.
- R2: After reset, `reg_rdata_o` reads 8'h10, `key_sts_o` is 1, `irq_o` is 0 and no request pulses are produced. The reset value 8'h10 means timeout code 00, first action 00, second action 01, mask 0 and flag 0.
- R3: When a press is accepted, the first-action field `reg_rdata_o[3:2]` is applied. Code 00 does nothing, 01 pulses `on_req_o`, 10 pulses `off_req_o` and 11 does nothing. Every request pulse lasts exactly one clock, and `on_req_o` and `off_req_o` are never high together.
- R4: An interrupt event sets the flag `reg_rdata_o[7]` on every debounced press and on every debounced release, whatever the action settings are.
- R5: When the hold reaches one timeout, the second-action field `reg_rdata_o[5:4]` is applied. Code 00 raises an interrupt event, 01 pulses `on_req_o`, 10 pulses `off_req_o` and 11 does nothing.
- R6: The timeout field `reg_rdata_o[1:0]` sets the timeout length in one-second ticks counted after the press: codes 00, 01, 10 and 11 give 1, 2, 4 and 8 ticks.
- R7: One further timeout after the second action, `off_req_o` pulses. Each stage fires at most once per press, so extra ticks while the key is still held produce no more requests.
- R8: A release clears the hold timer. After the next press the timeout starts again from zero.
- R9: A write sets the timeout, first-action and second-action fields (`reg_wdata_i[1:0]`, `[3:2]` and `[5:4]`) only while `unlock_i` is 1. While `unlock_i` is 0 those bits of the write are ignored.
- R10: `reg_wdata_i[6]` writes the mask at any time. `reg_wdata_i[7]`=1 clears the flag, and 0 leaves it unchanged. The flag is sticky. `irq_o` is the flag gated by a clear mask, and a masked event still sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_ni | input | 1 | Raw power key pin, low when pressed |
| ms_tick_i | input | 1 | One-clock debounce sample strobe (1 ms) |
| sec_tick_i | input | 1 | One-clock hold timing strobe (1 s) |
| unlock_i | input | 1 | High while the configuration fields accept writes |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Write data: [1:0] timeout, [3:2] first action, [5:4] second action, [6] mask, [7] flag clear |
| reg_rdata_o | output | 8 | Read data: [1:0] timeout, [3:2] first action, [5:4] second action, [6] mask, [7] flag |
| key_sts_o | output | 1 | Debounced key level, 0 when pressed |
| on_req_o | output | 1 | Power-on request pulse |
| off_req_o | output | 1 | Power-off request pulse |
| irq_o | output | 1 | Interrupt output, high while the flag is set and the mask is clear |

## Verification
The assertions check the following on every cycle:
- the debounced level moves only on a millisecond tick;
- the configuration stays frozen while the unlock input is low;
- a release forces the hold timer back to idle;
- request pulses last one clock and never overlap;
- every event lands in the flag.

Other behaviour can only be shown by the bench scenarios. These cover each action encoding, the exact tick count for each timeout code, the single tertiary off request during a long hold, and the rejection of a bouncing pin whose run is cut short.

// File: rtl/pkey_pkg.sv
package pkey_pkg;
  typedef enum logic [1:0] {
    PA_NONE = 2'b00,
    PA_ON   = 2'b01,
    PA_OFF  = 2'b10,
    PA_RSVD = 2'b11
  } prim_act_e;

  typedef enum logic [1:0] {
    SA_INT  = 2'b00,
    SA_ON   = 2'b01,
    SA_OFF  = 2'b10,
    SA_RSVD = 2'b11
  } sec_act_e;

  typedef enum logic [1:0] {
    HS_IDLE  = 2'b00,
    HS_WAIT1 = 2'b01,
    HS_WAIT2 = 2'b10,
    HS_DONE  = 2'b11
  } hold_st_e;

  localparam int TMO_W = 2;

  typedef struct packed {
    sec_act_e         sec;
    prim_act_e        prim;
    logic [TMO_W-1:0] tmo;
  } key_cfg_t;
endpackage

// File: rtl/pkey_debounce.sv
module pkey_debounce #(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_LEN     = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  input  logic tick_i,
  output logic level_o,
  output logic press_o,
  output logic release_o
);
  localparam int CNT_W = $clog2(DEB_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   raw;
  logic                   lvl_q, press_q, rel_q;
  logic [CNT_W-1:0]       cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_ni};
  end
  assign raw = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q   <= 1'b1;
      cnt_q   <= '0;
      press_q <= 1'b0;
      rel_q   <= 1'b0;
    end else begin
      press_q <= 1'b0;
      rel_q   <= 1'b0;
      if (tick_i) begin
        if (raw != lvl_q) begin
          if (cnt_q == CNT_W'(DEB_LEN - 1)) begin
            lvl_q   <= raw;
            cnt_q   <= '0;
            press_q <= ~raw;
            rel_q   <= raw;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else begin
          cnt_q <= '0;
        end
      end
    end
  end

  assign level_o   = lvl_q;
  assign press_o   = press_q;
  assign release_o = rel_q;

  AST_DEB_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(lvl_q)); // R1
endmodule

// File: rtl/pkey_hold_timer.sv
module pkey_hold_timer
  import pkey_pkg::*;
#(
  parameter int TW = TMO_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          level_i,
  input  logic          press_i,
  input  logic          tick_i,
  input  logic [TW-1:0] tmo_i,
  output logic          sec_fire_o,
  output logic          ter_fire_o
);
  localparam int CNT_W = (1 << TW);

  hold_st_e         st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic             sec_q, ter_q;
  logic             expired;

  assign lim     = {{(CNT_W-1){1'b0}}, 1'b1} << tmo_i;
  assign expired = (cnt_q >= lim - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= HS_IDLE;
      cnt_q <= '0;
      sec_q <= 1'b0;
      ter_q <= 1'b0;
    end else begin
      sec_q <= 1'b0;
      ter_q <= 1'b0;
      if (level_i) begin
        st_q  <= HS_IDLE;
        cnt_q <= '0;
      end else if (press_i) begin
        st_q  <= HS_WAIT1;
        cnt_q <= '0;
      end else if (tick_i && (st_q == HS_WAIT1 || st_q == HS_WAIT2)) begin
        if (expired) begin
          cnt_q <= '0;
          if (st_q == HS_WAIT1) begin
            sec_q <= 1'b1;
            st_q  <= HS_WAIT2;
          end else begin
            ter_q <= 1'b1;
            st_q  <= HS_DONE;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign sec_fire_o = sec_q;
  assign ter_fire_o = ter_q;

  AST_HOLD_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_i |=> (st_q == HS_IDLE && cnt_q == '0)); // R8
  AST_SEC_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_fire_o |=> !sec_fire_o); // R7
endmodule

// File: rtl/pkey_regs.sv
module pkey_regs
  import pkey_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  input  logic       unlock_i,
  input  logic       evt_i,
  output key_cfg_t   cfg_o,
  output logic       mask_o,
  output logic       flag_o,
  output logic [7:0] rdata_o
);
  key_cfg_t cfg_q;
  logic     mask_q, flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q.tmo  <= '0;
      cfg_q.prim <= PA_NONE;
      cfg_q.sec  <= SA_ON;
      mask_q     <= 1'b0;
    end else if (we_i) begin
      mask_q <= wdata_i[6];
      if (unlock_i) begin
        cfg_q.tmo  <= wdata_i[1:0];
        cfg_q.prim <= prim_act_e'(wdata_i[3:2]);
        cfg_q.sec  <= sec_act_e'(wdata_i[5:4]);
      end
    end
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    flag_q <= 1'b0;
    else if (evt_i)                 flag_q <= 1'b1;
    else if (we_i && wdata_i[7])    flag_q <= 1'b0;
  end

  assign cfg_o   = cfg_q;
  assign mask_o  = mask_q;
  assign flag_o  = flag_q;
  assign rdata_o = {flag_q, mask_q, cfg_q.sec, cfg_q.prim, cfg_q.tmo};

  AST_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlock_i |=> $stable(cfg_q)); // R9
  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> flag_q); // R10
endmodule

// File: rtl/pwr_key_ctrl.sv
module pwr_key_ctrl
  import pkey_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_LEN     = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       key_ni,
  input  logic       ms_tick_i,
  input  logic       sec_tick_i,
  input  logic       unlock_i,
  input  logic       reg_we_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       key_sts_o,
  output logic       on_req_o,
  output logic       off_req_o,
  output logic       irq_o
);
  logic     level, press, release_p;
  logic     sec_fire, ter_fire;
  logic     evt, mask, flag;
  key_cfg_t cfg;
  logic     on_q, off_q;

  pkey_debounce #(.SYNC_STAGES(SYNC_STAGES), .DEB_LEN(DEB_LEN)) u_deb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pin_ni    (key_ni),
    .tick_i    (ms_tick_i),
    .level_o   (level),
    .press_o   (press),
    .release_o (release_p)
  );

  pkey_hold_timer #(.TW(TMO_W)) u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .level_i    (level),
    .press_i    (press),
    .tick_i     (sec_tick_i),
    .tmo_i      (cfg.tmo),
    .sec_fire_o (sec_fire),
    .ter_fire_o (ter_fire)
  );

  assign evt = press | release_p | (sec_fire && cfg.sec == SA_INT);

  pkey_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .wdata_i  (reg_wdata_i),
    .unlock_i (unlock_i),
    .evt_i    (evt),
    .cfg_o    (cfg),
    .mask_o   (mask),
    .flag_o   (flag),
    .rdata_o  (reg_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_q  <= 1'b0;
      off_q <= 1'b0;
    end else begin
      on_q  <= (press && cfg.prim == PA_ON) || (sec_fire && cfg.sec == SA_ON);
      off_q <= (press && cfg.prim == PA_OFF) || (sec_fire && cfg.sec == SA_OFF) || ter_fire;
    end
  end

  assign on_req_o  = on_q;
  assign off_req_o = off_q;
  assign key_sts_o = level;
  assign irq_o     = flag & ~mask;

  AST_REQ_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(on_req_o && off_req_o)); // R3
  AST_ON_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    on_req_o |=> !on_req_o); // R3
  AST_OFF_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_req_o |=> !off_req_o); // R3
  AST_PRESS_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(key_sts_o) |=> reg_rdata_o[7]); // R4
endmodule

// File: tb/sim_pwr_key_ctrl.sv
module sim_pwr_key_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       key_n = 1'b1;
  logic       ms_tick = 1'b0;
  logic       sec_tick = 1'b0;
  logic       unlock = 1'b0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       sts, on_req, off_req, irq;

  int n_chk = 0, n_err = 0;
  int n_on = 0, n_off = 0;
  logic [1:0] s_tmo = 2'b00, s_prim = 2'b00, s_sec = 2'b01;
  logic       s_mask = 1'b0;

  always #5 clk = ~clk;

  pwr_key_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .key_ni(key_n), .ms_tick_i(ms_tick),
    .sec_tick_i(sec_tick), .unlock_i(unlock), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .key_sts_o(sts),
    .on_req_o(on_req), .off_req_o(off_req), .irq_o(irq)
  );

  always @(negedge clk) begin
    if (on_req)  n_on++;
    if (off_req) n_off++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick_ms();
    repeat (3) @(negedge clk);
    ms_tick = 1'b1;
    @(negedge clk);
    ms_tick = 1'b0;
  endtask

  task automatic tick_sec();
    @(negedge clk);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic clr);
    @(negedge clk);
    we = 1'b1;
    wdata = {clr, s_mask, s_sec, s_prim, s_tmo};
    @(negedge clk);
    we = 1'b0;
    @(negedge clk);
  endtask

  task automatic cfg(input logic [1:0] tmo, input logic [1:0] prim, input logic [1:0] sec);
    unlock = 1'b1;
    s_tmo = tmo; s_prim = prim; s_sec = sec;
    wr(1'b1);
    unlock = 1'b0;
  endtask

  task automatic press();
    key_n = 1'b0;
    repeat (4) tick_ms();
    repeat (4) @(negedge clk);
  endtask

  task automatic release_key();
    key_n = 1'b1;
    repeat (4) tick_ms();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R2 rdata", rdata, 8'h10);
    chk("R2 sts", sts, 1);
    chk("R2 irq", irq, 0);
    chk("R2 on", n_on, 0);
    chk("R2 off", n_off, 0);
  endtask

  task automatic t_debounce();
    cfg(2'b00, 2'b00, 2'b11);
    key_n = 1'b0;
    repeat (3) tick_ms();
    repeat (2) @(negedge clk);
    chk("R1 three samples", sts, 1);
    tick_ms();
    repeat (2) @(negedge clk);
    chk("R1 fourth sample", sts, 0);
    wr(1'b1);
    key_n = 1'b1;
    repeat (2) tick_ms();
    key_n = 1'b0;
    tick_ms();
    key_n = 1'b1;
    repeat (3) tick_ms();
    repeat (2) @(negedge clk);
    chk("R1 bounce rejected", sts, 0);
    chk("R1 no event on bounce", rdata[7], 0);
    tick_ms();
    repeat (2) @(negedge clk);
    chk("R1 release accepted", sts, 1);
  endtask

  task automatic t_prim(input logic [1:0] code, input int e_on, input int e_off);
    int on0, off0;
    cfg(2'b00, code, 2'b11);
    on0 = n_on; off0 = n_off;
    press();
    chk($sformatf("R3 prim %0d on", code), n_on - on0, e_on);
    chk($sformatf("R3 prim %0d off", code), n_off - off0, e_off);
    chk("R4 press event", rdata[7], 1);
    wr(1'b1);
    chk("R10 w1c clears", rdata[7], 0);
    release_key();
    chk("R4 release event", rdata[7], 1);
    chk("R3 no request on release", (n_on - on0) + (n_off - off0), e_on + e_off);
  endtask

  task automatic t_sec(input logic [1:0] code, input int e_on, input int e_off, input int e_flag);
    int on0, off0;
    cfg(2'b00, 2'b00, code);
    press();
    wr(1'b1);
    on0 = n_on; off0 = n_off;
    tick_sec();
    chk($sformatf("R5 sec %0d on", code), n_on - on0, e_on);
    chk($sformatf("R5 sec %0d off", code), n_off - off0, e_off);
    chk($sformatf("R5 sec %0d flag", code), rdata[7], e_flag);
    release_key();
  endtask

  task automatic t_hold(input logic [1:0] code);
    int on0, off0, lim;
    lim = 1 << code;
    cfg(code, 2'b00, 2'b01);
    press();
    on0 = n_on; off0 = n_off;
    repeat (lim - 1) tick_sec();
    chk($sformatf("R6 tmo %0d early", code), n_on - on0, 0);
    tick_sec();
    chk($sformatf("R6 tmo %0d fires", code), n_on - on0, 1);
    repeat (lim - 1) tick_sec();
    chk($sformatf("R7 tmo %0d tertiary early", code), n_off - off0, 0);
    tick_sec();
    chk($sformatf("R7 tmo %0d tertiary off", code), n_off - off0, 1);
    repeat (2 * lim) tick_sec();
    chk("R7 once per press on", n_on - on0, 1);
    chk("R7 once per press off", n_off - off0, 1);
    release_key();
  endtask

  task automatic t_cancel();
    int on0;
    cfg(2'b01, 2'b00, 2'b01);
    on0 = n_on;
    press();
    tick_sec();
    release_key();
    press();
    tick_sec();
    chk("R8 restart after release", n_on - on0, 0);
    tick_sec();
    chk("R8 fires after full timeout", n_on - on0, 1);
    release_key();
  endtask

  task automatic t_lock();
    cfg(2'b00, 2'b00, 2'b01);
    unlock = 1'b0;
    s_tmo = 2'b11; s_prim = 2'b10; s_sec = 2'b10; s_mask = 1'b1;
    wr(1'b0);
    chk("R9 locked fields kept", rdata[5:0], 6'b01_00_00);
    chk("R10 mask writable while locked", rdata[6], 1);
    s_tmo = 2'b00; s_prim = 2'b00; s_sec = 2'b01;
  endtask

  task automatic t_mask();
    wr(1'b1);
    press();
    chk("R10 masked flag set", rdata[7], 1);
    chk("R10 masked irq low", irq, 0);
    s_mask = 1'b0;
    wr(1'b0);
    chk("R10 sticky after write 0", rdata[7], 1);
    chk("R10 irq unmasked", irq, 1);
    wr(1'b1);
    chk("R10 irq cleared", irq, 0);
    release_key();
    wr(1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL R1 watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_debounce();
    t_prim(2'b00, 0, 0);
    t_prim(2'b01, 1, 0);
    t_prim(2'b10, 0, 1);
    t_prim(2'b11, 0, 0);
    t_sec(2'b00, 0, 0, 1);
    t_sec(2'b01, 1, 0, 0);
    t_sec(2'b10, 0, 1, 0);
    t_sec(2'b11, 0, 0, 0);
    for (int c = 0; c < 4; c++) t_hold(c[1:0]);
    t_cancel();
    t_lock();
    t_mask();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule